// File: doc/BRIEF.md
# Processor Reset and Exception Sequencer

This block sits between a processor core and its board-level status pins. Six asynchronous requests come in: hard reset, soft reset, machine check, checkstop input, system management interrupt and external interrupt. Each request passes through a two-flop synchronizer. A counter then checks that the request stayed asserted for its own minimum number of clocks. A request that meets its width is latched as pending until it is taken or a hard reset discards it. One fixed-priority arbiter picks at most one pending request per clock.

The block keeps three control bits of the machine state: external-interrupt enable, machine-check enable and vector prefix. For every exception it takes, it emits a one-cycle vector pulse carrying the fetch address. A taken exception other than hard reset also pulses the state-save strobe. Soft reset additionally pulses the state-clear strobe. Hard reset does three things: it turns the bus drivers off within a few clocks, forces the control bits to their initial values, and clears the checkstop output. When the hard reset is released, the block emits the absolute reset vector.

A machine check or checkstop input that arrives while machine checks are disabled does not produce a vector. Instead it raises a sticky checkstop output, and the block takes no further exceptions until the next hard reset. The core loads the control bits through a single-cycle write strobe.

Top module: `exc_seq_top`

## Requirements
- R1: While `rst_n` is low, `drv_oe` and `vec_valid` are 0. After `rst_n` is released, a `vec_valid` pulse with `vec_addr` = 0xFFF00100 appears on the third rising edge. After that pulse, `msr_ee`=0, `msr_me`=0, `msr_ip`=1 and `drv_oe`=1.
- R2: `drv_oe` drops to 0 by the third rising edge after `hreset_req` rises, which is within five clocks. While `hreset_req` is held, no vector is issued. The third edge after `hreset_req` falls issues vector 0xFFF00100 and sets `drv_oe` back to 1. Hard reset clears `cstop_out` and discards every pending request.
- R3: A soft reset request held for fewer than `SRST_MIN_CYC` (default 2) clocks is ignored. A request held for exactly that long is honoured even if it is dropped immediately afterwards. It yields offset 0x100 with `save_state` and `msr_clear` pulsed together with `vec_valid`, and it leaves `msr_ee`=0 and `msr_me`=0.
- R4: An external interrupt needs `EXT_MIN_CYC` (default 3) clocks of assertion and maps to offset 0x500. It is taken only while `msr_ee`=1; once qualified it waits as pending until `msr_ee` is set.
- R5: A system management interrupt needs `SMI_MIN_CYC` (default 3) clocks of assertion and maps to offset 0x1400. It is gated by `msr_ee` in the same way as the external interrupt.
- R6: A machine check or checkstop input taken with `msr_me`=1 maps to offset 0x200 and clears both `msr_me` and `msr_ee`.
- R7: A machine check or checkstop input that becomes pending with `msr_me`=0 issues no vector and sets `cstop_out`. `cstop_out` stays 1, and no exception is taken, until a hard reset.
- R8: Among pending requests, the order from highest to lowest is: soft reset, then machine check/checkstop, then system management interrupt, then external interrupt. A request that loses stays pending.
- R9: The vector address is the base plus the offset. The base is 0xFFF00000 when `msr_ip`=1 and 0x00000000 when `msr_ip`=0. A `msr_wr` pulse loads `msr_ee`, `msr_me` and `msr_ip` from `msr_wr_ee`, `msr_wr_me` and `msr_wr_ip`; the new values are visible after the next edge.
- R10: For a request held steadily from idle, `vec_valid` appears on rising edge number (minimum width + 3) after the request rises.
- R11: Every taken exception clears `msr_ee`. `save_state` pulses with every vector except the hard-reset vector. `msr_clear` pulses only with the soft-reset vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hreset_req | input | 1 | Asynchronous hard reset request, active high |
| sreset_req | input | 1 | Asynchronous soft reset request, active high |
| mchk_req | input | 1 | Asynchronous machine check request |
| cstop_req | input | 1 | Asynchronous checkstop input request |
| smi_req | input | 1 | Asynchronous system management interrupt |
| ext_req | input | 1 | Asynchronous external interrupt |
| msr_wr | input | 1 | Load strobe for the control bits |
| msr_wr_ee | input | 1 | External-interrupt enable value to load |
| msr_wr_me | input | 1 | Machine-check enable value to load |
| msr_wr_ip | input | 1 | Vector prefix value to load |
| vec_valid | output | 1 | One-cycle pulse: fetch from `vec_addr` |
| vec_addr | output | 32 | Exception vector address |
| save_state | output | 1 | Pulse: save program counter and machine state |
| msr_clear | output | 1 | Pulse: clear machine state register (soft reset) |
| drv_oe | output | 1 | Bus driver enable; 0 puts drivers in high impedance |
| cstop_out | output | 1 | Sticky checkstop indication |
| msr_ee | output | 1 | Current external-interrupt enable |
| msr_me | output | 1 | Current machine-check enable |
| msr_ip | output | 1 | Current vector prefix |

## Verification
A qualification counter that is off by one moves the `vec_valid` pulse by a whole clock. It also turns a pulse that should be ignored into a vector, or the reverse, so the exact-latency and short-pulse checks see it within about six clocks of the stimulus. A pending bit that is lost or set wrongly, or a wrong priority order, shows up as a missing or wrong `vec_addr` when the blocked request is released by a control-bit write one clock later. Corrupted control bits show directly on `msr_ee`, `msr_me` and `msr_ip`, and also in the base chosen for the next vector. A checkstop that is not sticky shows on `cstop_out` on the following edge.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NSRC     = 6;
  localparam int IDX_HARD = 0;
  localparam int IDX_SOFT = 1;
  localparam int IDX_MCHK = 2;
  localparam int IDX_CSTP = 3;
  localparam int IDX_SMI  = 4;
  localparam int IDX_EXT  = 5;

  localparam logic [31:0] BASE_HIGH  = 32'hFFF0_0000;
  localparam logic [31:0] BASE_LOW   = 32'h0000_0000;
  localparam logic [31:0] OFS_RESET  = 32'h0000_0100;
  localparam logic [31:0] OFS_MCHK   = 32'h0000_0200;
  localparam logic [31:0] OFS_EXT    = 32'h0000_0500;
  localparam logic [31:0] OFS_SMI    = 32'h0000_1400;

  typedef enum logic [2:0] {
    EK_NONE,
    EK_SOFT,
    EK_MCHK,
    EK_SMI,
    EK_EXT
  } exc_kind_e;

  function automatic logic [31:0] kind_offset(input exc_kind_e k);
    case (k)
      EK_SOFT: kind_offset = OFS_RESET;
      EK_MCHK: kind_offset = OFS_MCHK;
      EK_SMI:  kind_offset = OFS_SMI;
      EK_EXT:  kind_offset = OFS_EXT;
      default: kind_offset = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/exc_sync2.sv
module exc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/exc_pulse_qual.sv
module exc_pulse_qual #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic hit
);

  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] CNT_MAX  = W'(LEN);
  localparam logic [W-1:0] CNT_LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  // saturating count of consecutive high cycles
  always_comb begin
    cnt_d = cnt_q;
    if (!lvl) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // single pulse on the LEN-th consecutive high cycle
  assign hit = lvl && (cnt_q == CNT_LAST);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic [NSRC-1:1] pend,
  input  logic            ee,
  input  logic            me,
  input  logic            stopped,
  output logic [NSRC-1:1] clr,
  output exc_kind_e       kind,
  output logic            go_stop
);

  always_comb begin
    clr     = '0;
    kind    = EK_NONE;
    go_stop = 1'b0;
    if (!stopped) begin
      if (pend[IDX_SOFT]) begin
        clr[IDX_SOFT] = 1'b1;
        kind          = EK_SOFT;
      end else if (pend[IDX_MCHK] || pend[IDX_CSTP]) begin
        clr[IDX_MCHK] = 1'b1;
        clr[IDX_CSTP] = 1'b1;
        if (me) begin
          kind = EK_MCHK;
        end else begin
          go_stop = 1'b1;
        end
      end else if (pend[IDX_SMI] && ee) begin
        clr[IDX_SMI] = 1'b1;
        kind         = EK_SMI;
      end else if (pend[IDX_EXT] && ee) begin
        clr[IDX_EXT] = 1'b1;
        kind         = EK_EXT;
      end
    end
  end

endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int SRST_MIN_CYC = 2,
  parameter int MCHK_MIN_CYC = 1,
  parameter int CSTP_MIN_CYC = 1,
  parameter int SMI_MIN_CYC  = 3,
  parameter int EXT_MIN_CYC  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hreset_req,
  input  logic        sreset_req,
  input  logic        mchk_req,
  input  logic        cstop_req,
  input  logic        smi_req,
  input  logic        ext_req,
  input  logic        msr_wr,
  input  logic        msr_wr_ee,
  input  logic        msr_wr_me,
  input  logic        msr_wr_ip,
  output logic        vec_valid,
  output logic [31:0] vec_addr,
  output logic        save_state,
  output logic        msr_clear,
  output logic        drv_oe,
  output logic        cstop_out,
  output logic        msr_ee,
  output logic        msr_me,
  output logic        msr_ip
);

  // ---------------- reset release synchronizer
  logic [1:0] rst_sh_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= 2'b00;
    end else begin
      rst_sh_q <= {rst_sh_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sh_q[1];

  // ---------------- input synchronizers
  logic [NSRC-1:0] raw_req;
  logic [NSRC-1:0] sync_req;
  logic            hard_s;

  assign raw_req = {ext_req, smi_req, cstop_req, mchk_req, sreset_req, hreset_req};

  exc_sync2 #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (raw_req),
    .q     (sync_req)
  );

  assign hard_s = sync_req[IDX_HARD];

  // ---------------- per-source pulse width qualifiers
  logic [NSRC-1:1] hit;

  for (genvar g = 1; g < NSRC; g++) begin : g_qual
    localparam int LEN = (g == IDX_SOFT) ? SRST_MIN_CYC :
                         (g == IDX_MCHK) ? MCHK_MIN_CYC :
                         (g == IDX_CSTP) ? CSTP_MIN_CYC :
                         (g == IDX_SMI)  ? SMI_MIN_CYC  : EXT_MIN_CYC;
    exc_pulse_qual #(.LEN(LEN)) u_qual (
      .clk   (clk),
      .rst_n (rst_int_n),
      .lvl   (sync_req[g]),
      .hit   (hit[g])
    );
  end

  // ---------------- state
  logic [NSRC-1:1] pend_q, pend_d;
  logic            in_hrst_q, in_hrst_d;
  logic            ee_q, ee_d;
  logic            me_q, me_d;
  logic            ip_q, ip_d;
  logic            stop_q, stop_d;
  logic            oe_q, oe_d;
  logic            vv_q, vv_d;
  logic [31:0]     va_q, va_d;
  logic            sv_q, sv_d;
  logic            mc_q, mc_d;

  logic [NSRC-1:1] arb_clr;
  exc_kind_e       arb_kind;
  logic            arb_stop;

  exc_arbiter u_arb (
    .pend    (pend_q),
    .ee      (ee_q),
    .me      (me_q),
    .stopped (stop_q),
    .clr     (arb_clr),
    .kind    (arb_kind),
    .go_stop (arb_stop)
  );

  logic hard_busy;
  logic hard_done;
  assign hard_busy = hard_s | in_hrst_q;
  assign hard_done = in_hrst_q & ~hard_s;

  // ---------------- next state
  always_comb begin
    pend_d    = pend_q;
    in_hrst_d = hard_s;
    oe_d      = ~hard_s;
    ee_d      = ee_q;
    me_d      = me_q;
    ip_d      = ip_q;
    stop_d    = stop_q;
    vv_d      = 1'b0;
    va_d      = va_q;
    sv_d      = 1'b0;
    mc_d      = 1'b0;
    if (hard_busy) begin
      pend_d = '0;
      ee_d   = 1'b0;
      me_d   = 1'b0;
      ip_d   = 1'b1;
      stop_d = 1'b0;
      if (hard_done) begin
        vv_d = 1'b1;
        va_d = BASE_HIGH + OFS_RESET;
      end
    end else begin
      pend_d = (pend_q | hit) & ~arb_clr;
      if (msr_wr) begin
        ee_d = msr_wr_ee;
        me_d = msr_wr_me;
        ip_d = msr_wr_ip;
      end
      if (arb_stop) begin
        stop_d = 1'b1;
      end
      if (arb_kind != EK_NONE) begin
        vv_d = 1'b1;
        va_d = (ip_q ? BASE_HIGH : BASE_LOW) + kind_offset(arb_kind);
        sv_d = 1'b1;
        ee_d = 1'b0;
        if (arb_kind == EK_SOFT) begin
          mc_d = 1'b1;
          me_d = 1'b0;
        end
        if (arb_kind == EK_MCHK) begin
          me_d = 1'b0;
        end
      end
    end
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q    <= '0;
      in_hrst_q <= 1'b1;
      oe_q      <= 1'b0;
      ee_q      <= 1'b0;
      me_q      <= 1'b0;
      ip_q      <= 1'b1;
      stop_q    <= 1'b0;
      vv_q      <= 1'b0;
      va_q      <= '0;
      sv_q      <= 1'b0;
      mc_q      <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      in_hrst_q <= in_hrst_d;
      oe_q      <= oe_d;
      ee_q      <= ee_d;
      me_q      <= me_d;
      ip_q      <= ip_d;
      stop_q    <= stop_d;
      vv_q      <= vv_d;
      va_q      <= va_d;
      sv_q      <= sv_d;
      mc_q      <= mc_d;
    end
  end

  assign vec_valid  = vv_q;
  assign vec_addr   = va_q;
  assign save_state = sv_q;
  assign msr_clear  = mc_q;
  assign drv_oe     = oe_q;
  assign cstop_out  = stop_q;
  assign msr_ee     = ee_q;
  assign msr_me     = me_q;
  assign msr_ip     = ip_q;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hard_s,
  input logic        vec_valid,
  input logic [31:0] vec_addr,
  input logic        save_state,
  input logic        msr_clear,
  input logic        drv_oe,
  input logic        cstop_out,
  input logic        msr_ee,
  input logic        msr_me
);

  assert_drv_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hard_s |=> !drv_oe);

  assert_cstop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cstop_out && !hard_s) |=> cstop_out);

  assert_cstop_needs_me_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cstop_out) |-> !$past(msr_me));

  assert_ext_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr[15:0] == 16'h0500) |-> $past(msr_ee));

  assert_smi_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr[15:0] == 16'h1400) |-> $past(msr_ee));

  assert_clear_with_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msr_clear |-> (vec_valid && save_state && vec_addr[15:0] == 16'h0100));

  assert_save_with_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
    save_state |-> vec_valid);

  assert_legal_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((vec_addr[31:20] == 12'hFFF || vec_addr[31:20] == 12'h000) &&
                   (vec_addr[19:0] == 20'h00100 || vec_addr[19:0] == 20'h00200 ||
                    vec_addr[19:0] == 20'h00500 || vec_addr[19:0] == 20'h01400)));

endmodule

bind exc_seq_top exc_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hard_s     (hard_s),
  .vec_valid  (vec_valid),
  .vec_addr   (vec_addr),
  .save_state (save_state),
  .msr_clear  (msr_clear),
  .drv_oe     (drv_oe),
  .cstop_out  (cstop_out),
  .msr_ee     (msr_ee),
  .msr_me     (msr_me)
);

// File: tb/tb_exc_seq_top.sv
`timescale 1ns/1ps
module tb_exc_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hreset_req, sreset_req, mchk_req, cstop_req, smi_req, ext_req;
  logic        msr_wr, msr_wr_ee, msr_wr_me, msr_wr_ip;
  logic        vec_valid;
  logic [31:0] vec_addr;
  logic        save_state, msr_clear, drv_oe, cstop_out, msr_ee, msr_me, msr_ip;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  exc_seq_top dut (
    .clk(clk), .rst_n(rst_n),
    .hreset_req(hreset_req), .sreset_req(sreset_req), .mchk_req(mchk_req),
    .cstop_req(cstop_req), .smi_req(smi_req), .ext_req(ext_req),
    .msr_wr(msr_wr), .msr_wr_ee(msr_wr_ee), .msr_wr_me(msr_wr_me), .msr_wr_ip(msr_wr_ip),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .save_state(save_state),
    .msr_clear(msr_clear), .drv_oe(drv_oe), .cstop_out(cstop_out),
    .msr_ee(msr_ee), .msr_me(msr_me), .msr_ip(msr_ip)
  );

  // source codes used by the bench: 4 = smi, 5 = ext
  function automatic logic [31:0] exp_addr(input logic ip, input int src);
    logic [31:0] base;
    base = ip ? 32'hFFF0_0000 : 32'h0;
    return base + ((src == 4) ? 32'h1400 : 32'h0500);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic msr_write(input logic ee, input logic me, input logic ip);
    @(negedge clk);
    msr_wr = 1'b1; msr_wr_ee = ee; msr_wr_me = me; msr_wr_ip = ip;
    @(negedge clk);
    msr_wr = 1'b0;
  endtask

  // waits for a vector; returns latency in negedges (-1 if none)
  task automatic wait_vec(input int lim, output int lat, output logic [31:0] a,
                          output logic sv, output logic mc);
    bit found;
    found = 1'b0; lat = -1; a = '0; sv = 1'b0; mc = 1'b0;
    for (int i = 1; i <= lim; i++) begin
      if (!found) begin
        @(negedge clk);
        if (vec_valid) begin
          found = 1'b1; lat = i; a = vec_addr; sv = save_state; mc = msr_clear;
        end
      end
    end
  endtask

  task automatic expect_vec(input int lim, input logic [31:0] exp, input string tag);
    int lat; logic [31:0] a; logic sv, mc;
    wait_vec(lim, lat, a, sv, mc);
    chk(lat > 0 && a == exp, tag, a, exp);
  endtask

  task automatic expect_none(input int n, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (vec_valid) seen = 1'b1;
    end
    chk(!seen, tag, {31'h0, seen}, 32'h0);
  endtask

  task automatic pulse(input int src, input int n);
    @(negedge clk);
    case (src)
      1: sreset_req = 1'b1;
      2: mchk_req   = 1'b1;
      3: cstop_req  = 1'b1;
      4: smi_req    = 1'b1;
      default: ext_req = 1'b1;
    endcase
    repeat (n) @(negedge clk);
    sreset_req = 1'b0; mchk_req = 1'b0; cstop_req = 1'b0; smi_req = 1'b0; ext_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat; logic [31:0] a; logic sv, mc;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    hreset_req = 0; sreset_req = 0; mchk_req = 0; cstop_req = 0; smi_req = 0; ext_req = 0;
    msr_wr = 0; msr_wr_ee = 0; msr_wr_me = 0; msr_wr_ip = 0;
    repeat (3) @(negedge clk);
    chk(drv_oe == 1'b0 && vec_valid == 1'b0, "R1 reset outputs", {30'h0, drv_oe, vec_valid}, 32'h0);

    // R1: power-on vector on third edge
    rst_n = 1'b1;
    wait_vec(10, lat, a, sv, mc);
    chk(lat == 3, "R1 vector latency", lat, 3);
    chk(a == 32'hFFF0_0100 && sv == 1'b0, "R1 vector address", a, 32'hFFF0_0100);
    chk({msr_ee, msr_me, msr_ip, drv_oe} == 4'b0011, "R1 control bits", {msr_ee, msr_me, msr_ip, drv_oe}, 4'b0011);

    // R9: write control bits
    msr_write(1, 1, 0);
    chk({msr_ee, msr_me, msr_ip} == 3'b110, "R9 msr write", {msr_ee, msr_me, msr_ip}, 3'b110);

    // R10/R4/R11: held external interrupt
    @(negedge clk); ext_req = 1'b1;
    wait_vec(12, lat, a, sv, mc);
    chk(lat == 6, "R10 ext latency", lat, 6);
    chk(a == 32'h0000_0500, "R4 ext vector", a, 32'h500);
    chk(sv == 1'b1 && mc == 1'b0, "R11 ext strobes", {sv, mc}, 2'b10);
    ext_req = 1'b0;
    chk(msr_ee == 1'b0, "R11 ee cleared", msr_ee, 0);

    // R4: masked ext waits as pending
    pulse(5, 4);
    expect_none(8, "R4 ext masked");
    msr_write(1, 1, 0);
    expect_vec(4, 32'h0000_0500, "R4 ext after enable");

    // R3: soft reset too short, then minimum width dropped at once
    pulse(1, 1);
    expect_none(8, "R3 short soft ignored");
    pulse(1, 2);
    wait_vec(8, lat, a, sv, mc);
    chk(lat == 3, "R3 soft latency after drop", lat, 3);
    chk(a == 32'h0000_0100, "R3 soft vector", a, 32'h100);
    chk(sv && mc, "R3 soft strobes", {sv, mc}, 2'b11);
    chk({msr_ee, msr_me} == 2'b00, "R3 soft clears bits", {msr_ee, msr_me}, 0);

    // R6/R9: machine check with high base
    msr_write(1, 1, 1);
    @(negedge clk); mchk_req = 1'b1;
    wait_vec(8, lat, a, sv, mc);
    mchk_req = 1'b0;
    chk(lat == 4, "R10 mchk latency", lat, 4);
    chk(a == 32'hFFF0_0200, "R6 mchk vector", a, 32'hFFF0_0200);
    chk({msr_ee, msr_me} == 2'b00, "R6 mchk clears bits", {msr_ee, msr_me}, 0);

    // R7: checkstop with machine checks disabled
    pulse(3, 2);
    expect_none(8, "R7 no vector on checkstop");
    chk(cstop_out == 1'b1, "R7 checkstop set", cstop_out, 1);
    msr_write(1, 0, 0);
    pulse(5, 4);
    expect_none(8, "R7 exceptions blocked");
    chk(cstop_out == 1'b1, "R7 checkstop sticky", cstop_out, 1);

    // R2: hard reset
    @(negedge clk); hreset_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(drv_oe == 1'b0, "R2 drivers off", drv_oe, 0);
    expect_none(6, "R2 no vector while held");
    chk(cstop_out == 1'b0, "R2 checkstop cleared", cstop_out, 0);
    hreset_req = 1'b0;
    wait_vec(8, lat, a, sv, mc);
    chk(lat == 3 && a == 32'hFFF0_0100, "R2 release vector", a, 32'hFFF0_0100);
    chk(drv_oe == 1'b1, "R2 drivers back", drv_oe, 1);
    expect_none(6, "R2 pending discarded");

    // R8: mchk beats smi on same edge, smi stays pending
    msr_write(1, 1, 0);
    @(negedge clk); smi_req = 1'b1;
    repeat (2) @(negedge clk); mchk_req = 1'b1;
    wait_vec(8, lat, a, sv, mc);
    smi_req = 1'b0; mchk_req = 1'b0;
    chk(a == 32'h0000_0200, "R8 mchk over smi", a, 32'h200);
    msr_write(1, 1, 0);
    expect_vec(4, 32'h0000_1400, "R5 smi after mchk");

    // R8: soft beats pending ext
    pulse(5, 4);
    pulse(1, 2);
    expect_vec(8, 32'h0000_0100, "R8 soft over ext");
    msr_write(1, 1, 0);
    expect_vec(4, 32'h0000_0500, "R8 ext after soft");

    // R8: smi beats ext when both pending
    @(negedge clk); smi_req = 1'b1; ext_req = 1'b1;
    repeat (4) @(negedge clk); smi_req = 1'b0; ext_req = 1'b0;
    expect_none(4, "R8 both masked");
    msr_write(1, 1, 0);
    expect_vec(4, 32'h0000_1400, "R8 smi over ext");
    msr_write(1, 1, 0);
    expect_vec(4, 32'h0000_0500, "R8 ext last");

    // random: R4/R5/R9 widths, gating and base
    for (int it = 0; it < 24; it++) begin
      logic ee_r, ip_r;
      int src, dur;
      ee_r = 1'($urandom_range(0, 1));
      ip_r = 1'($urandom_range(0, 1));
      src  = $urandom_range(4, 5);
      dur  = $urandom_range(1, 5);
      msr_write(ee_r, 1, ip_r);
      pulse(src, dur);
      if (dur >= 3 && ee_r) begin
        expect_vec(8, exp_addr(ip_r, src), (src == 4) ? "R5 random smi" : "R4 random ext");
      end else if (dur >= 3) begin
        expect_none(6, "R9 random masked");
        msr_write(1, 1, ip_r);
        expect_vec(4, exp_addr(ip_r, src), (src == 4) ? "R5 random late smi" : "R4 random late ext");
      end else begin
        expect_none(6, "R4 random short");
        msr_write(1, 1, ip_r);
        expect_none(4, "R5 random short stays dropped");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule